// File: doc/BRIEF.md
# Passive-Serial Bitstream Loader

This block is the master side of a passive-serial configuration link. On a start pulse it resets the target device through an active-low config line. It waits for the target to acknowledge the reset and for the target to report that it is ready. It then clocks the image out one bit at a time on a serial clock and data pair. Image bytes come in on a valid/ready byte stream, and the image length in bytes is captured at start.

Config-done is examined only at byte boundaries. The load ends with a one-cycle done or fail pulse, and the elapsed cycle count is presented with that pulse. Once a load is finished, the block releases all three drive lines through their output enables, so an external programmer can use the pins. When an earlier external load is flagged together with the correct 32-bit key, the block skips the load and reports success at once. In that case it also pulses a clear request so the next start performs a normal load.

Back-pressure on the byte stream works as follows. `bs_ready` is high only while the loader waits at a byte boundary, and a byte moves on a cycle with both `bs_valid` and `bs_ready` high. The source may hold `bs_valid` low for any number of cycles. During that time the serial clock stays low and nothing else advances. The loader never takes more bytes than the captured length. The status and config-done inputs pass through a `SYNC_STAGES`-deep synchronizer before the sequencer uses them.

Top module: `ps_cfg_loader`

## Requirements
- R1: While the loader is idle (after reset and from the cycle of every done or fail pulse), the config, clock and data output enables are all low; while it is busy they are all high.
- R2: A load starts with a cycle in which config is driven high and the serial clock low. Config is then driven low and held low for at least `RESET_HOLD` cycles.
- R3: Config stays low until the synchronized status input or config-done input reads low; only then is config driven high.
- R4: No rising serial-clock edge occurs until config is high and the synchronized status input has been seen high.
- R5: Every consumed byte produces exactly 8 rising clock edges, and the data line at rising edge k (k = 0..7) carries bit k of the byte, least-significant bit first.
- R6: The data line changes only while the clock is low, and each clock phase, high or low, lasts at least `HALF_PER` system cycles.
- R7: `bs_ready` is high only at a byte boundary with the clock low. Exactly one byte is consumed per handshake, and the clock stays low while `bs_valid` is low.
- R8: Config-done is checked once before the first byte and once after each complete byte. If it reads high while fewer than `img_len` bytes have been consumed, `done` pulses and no further byte is taken.
- R9: When the consumed count reaches `img_len` at a boundary, `fail` pulses. This includes the case where config-done is first seen high at that final boundary. An `img_len` of 0 fails with no clock edge.
- R10: A start with `byp_flag` high and `byp_key` equal to 0xAFFEAFFE never enters busy. It gives a `done` pulse and a `byp_clr` pulse one cycle later with `elapsed` 0. Any other key value runs a normal load.
- R11: `done` and `fail` are single-cycle and never high together. `elapsed` then equals the number of cycles `busy` was high for that load and holds until the next start.
- R12: A start pulse while busy is ignored; the running load and its cycle count continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (pulse, acted on only when idle) |
| img_len | input | LEN_W | Image length in bytes, captured at start |
| byp_flag | input | 1 | An external load has been flagged |
| byp_key | input | 32 | Key word qualifying the bypass flag |
| byp_clr | output | 1 | One-cycle request to clear the bypass flag |
| bs_valid | input | 1 | Image byte available |
| bs_data | input | 8 | Image byte |
| bs_ready | output | 1 | Loader takes a byte this cycle if valid |
| cfg_n_o | output | 1 | Active-low config line value |
| cfg_n_oe | output | 1 | Output enable for config |
| dclk_o | output | 1 | Serial clock value |
| dclk_oe | output | 1 | Output enable for serial clock |
| dat_o | output | 1 | Serial data value |
| dat_oe | output | 1 | Output enable for serial data |
| status_n_i | input | 1 | Active-low status from target (asynchronous) |
| cdone_i | input | 1 | Config-done from target (asynchronous) |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure pulse |
| elapsed | output | CNT_W | Busy cycles of the last load |

## Verification
The bench builds the loader with `RESET_HOLD` = 4, `HALF_PER` = 2, `SYNC_STAGES` = 2 and `LEN_W` = 8. The short reset hold keeps each load to a few hundred cycles. Two-cycle clock phases exercise the phase counter's wrap, and the two-stage synchronizer sets a real lag between a target response and the byte boundary at which it takes effect. With these values, a bench-side target model can raise config-done in the middle of a chosen byte, and that byte becomes the last one sent. This reaches the early-success, never-done and done-at-final-byte outcomes, as well as a stalled stream, a held reset acknowledge and a zero-length image, all within a short run.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_RST,
    ST_ACK,
    ST_RDY,
    ST_CHECK,
    ST_FETCH,
    ST_SHIFT
  } ld_state_t;

  localparam logic [31:0] BYPASS_KEY = 32'hAFFE_AFFE;
endpackage

// File: rtl/ps_cfg_sync.sv
module ps_cfg_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int NS = (STAGES < 1) ? 1 : STAGES;

  logic [NS-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < NS; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[NS-1];
endmodule

// File: rtl/ps_cfg_shifter.sv
module ps_cfg_shifter #(
  parameter int HALF_PER = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] byte_in,
  output logic       dclk,
  output logic       dat,
  output logic       byte_done
);
  localparam int PH = (HALF_PER < 1) ? 1 : HALF_PER;
  localparam int PW = $clog2(PH + 1);

  logic [7:0]    sh;
  logic [2:0]    bit_idx;
  logic [PW-1:0] ph_cnt;
  logic          active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      bit_idx   <= '0;
      ph_cnt    <= '0;
      dclk      <= 1'b0;
      active    <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (load) begin
        sh      <= byte_in;
        bit_idx <= '0;
        ph_cnt  <= '0;
        dclk    <= 1'b0;
        active  <= 1'b1;
      end else if (active) begin
        if (ph_cnt == PW'(PH - 1)) begin
          ph_cnt <= '0;
          if (!dclk) begin
            dclk <= 1'b1;
          end else begin
            dclk    <= 1'b0;
            sh      <= {1'b0, sh[7:1]};
            bit_idx <= bit_idx + 3'd1;
            if (bit_idx == 3'd7) begin
              active    <= 1'b0;
              byte_done <= 1'b1;
            end
          end
        end else begin
          ph_cnt <= ph_cnt + PW'(1);
        end
      end
    end
  end

  assign dat = sh[0];

  // phase-length monitors for the checks below
  logic [PW-1:0] hi_run, lo_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
    end else begin
      if (dclk) begin
        lo_run <= '0;
        if (hi_run != PW'(PH)) hi_run <= hi_run + PW'(1);
      end else begin
        hi_run <= '0;
        if (lo_run != PW'(PH)) lo_run <= lo_run + PW'(1);
      end
    end
  end

  a_r6_data_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk && $past(dclk)) |-> $stable(dat));
  a_r6_high_phase_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dclk) |-> (hi_run == PW'(PH)));
  a_r6_low_phase_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk) |-> (lo_run == PW'(PH)));
endmodule

// File: rtl/ps_cfg_seq.sv
module ps_cfg_seq
  import ps_cfg_pkg::*;
#(
  parameter int RESET_HOLD = 64,
  parameter int LEN_W      = 24,
  parameter int CNT_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] img_len,
  input  logic             byp_flag,
  input  logic [31:0]      byp_key,
  input  logic             status_s,
  input  logic             cdone_s,
  input  logic             bs_valid,
  input  logic             byte_done,
  output logic             busy,
  output logic             cfg_n,
  output logic             bs_ready,
  output logic             load,
  output logic             done,
  output logic             fail,
  output logic             byp_clr,
  output logic [CNT_W-1:0] elapsed
);
  localparam int RH = (RESET_HOLD < 1) ? 1 : RESET_HOLD;
  localparam int RW = $clog2(RH + 1);
  localparam int LW = RW + 1;

  ld_state_t        st;
  logic [RW-1:0]    tmr;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] sent;

  assign busy     = (st != ST_IDLE);
  assign cfg_n    = !((st == ST_RST) || (st == ST_ACK));
  assign bs_ready = (st == ST_FETCH);
  assign load     = bs_ready && bs_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      tmr     <= '0;
      len_q   <= '0;
      sent    <= '0;
      elapsed <= '0;
      done    <= 1'b0;
      fail    <= 1'b0;
      byp_clr <= 1'b0;
    end else begin
      done    <= 1'b0;
      fail    <= 1'b0;
      byp_clr <= 1'b0;
      if (st != ST_IDLE) elapsed <= elapsed + CNT_W'(1);
      case (st)
        ST_IDLE: begin
          if (start) begin
            elapsed <= '0;
            if (byp_flag && (byp_key == BYPASS_KEY)) begin
              done    <= 1'b1;
              byp_clr <= 1'b1;
            end else begin
              st    <= ST_PREP;
              len_q <= img_len;
              sent  <= '0;
            end
          end
        end
        ST_PREP: begin
          tmr <= '0;
          st  <= ST_RST;
        end
        ST_RST: begin
          if (tmr == RW'(RH - 1)) st <= ST_ACK;
          else tmr <= tmr + RW'(1);
        end
        ST_ACK:   if (!status_s || !cdone_s) st <= ST_RDY;
        ST_RDY:   if (status_s) st <= ST_CHECK;
        ST_CHECK: begin
          if (sent >= len_q) begin
            fail <= 1'b1;
            st   <= ST_IDLE;
          end else if (cdone_s) begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            st <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (bs_valid) begin
            sent <= sent + LEN_W'(1);
            st   <= ST_SHIFT;
          end
        end
        ST_SHIFT: if (byte_done) st <= ST_CHECK;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  // length of the current low stretch on config, for the hold check
  logic [LW-1:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= '0;
    else if (busy && !cfg_n) begin
      if (low_run != LW'(RH)) low_run <= low_run + LW'(1);
    end else low_run <= '0;
  end

  a_r2_reset_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $rose(cfg_n)) |-> (low_run == LW'(RH)));
  a_r3_release_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $rose(cfg_n)) |-> ($past(!status_s) || $past(!cdone_s)));
  a_r8_done_with_bytes_left: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(busy)) |-> ($past(sent) < $past(len_q)));
  a_r9_fail_when_spent: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> ($past(sent) >= $past(len_q)));
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
  a_r11_pulse_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |-> !busy);
  a_r12_len_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(len_q));
endmodule

// File: rtl/ps_cfg_loader.sv
module ps_cfg_loader #(
  parameter int RESET_HOLD  = 64,
  parameter int HALF_PER    = 2,
  parameter int SYNC_STAGES = 2,
  parameter int LEN_W       = 24,
  parameter int CNT_W       = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] img_len,
  input  logic             byp_flag,
  input  logic [31:0]      byp_key,
  output logic             byp_clr,
  input  logic             bs_valid,
  input  logic [7:0]       bs_data,
  output logic             bs_ready,
  output logic             cfg_n_o,
  output logic             cfg_n_oe,
  output logic             dclk_o,
  output logic             dclk_oe,
  output logic             dat_o,
  output logic             dat_oe,
  input  logic             status_n_i,
  input  logic             cdone_i,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic [CNT_W-1:0] elapsed
);
  logic [1:0] sync_q;
  logic       load;
  logic       byte_done;

  ps_cfg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({status_n_i, cdone_i}),
    .q     (sync_q)
  );

  ps_cfg_seq #(.RESET_HOLD(RESET_HOLD), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .img_len   (img_len),
    .byp_flag  (byp_flag),
    .byp_key   (byp_key),
    .status_s  (sync_q[1]),
    .cdone_s   (sync_q[0]),
    .bs_valid  (bs_valid),
    .byte_done (byte_done),
    .busy      (busy),
    .cfg_n     (cfg_n_o),
    .bs_ready  (bs_ready),
    .load      (load),
    .done      (done),
    .fail      (fail),
    .byp_clr   (byp_clr),
    .elapsed   (elapsed)
  );

  ps_cfg_shifter #(.HALF_PER(HALF_PER)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .byte_in   (bs_data),
    .dclk      (dclk_o),
    .dat       (dat_o),
    .byte_done (byte_done)
  );

  assign cfg_n_oe = busy;
  assign dclk_oe  = busy;
  assign dat_oe   = busy;

  a_r7_ready_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    bs_ready |-> !dclk_o);
  a_r4_edge_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk_o) |-> (cfg_n_o && busy && sync_q[1]));
  a_r1_clock_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dclk_o);
endmodule

// File: tb/ps_cfg_loader_test.sv
`timescale 1ns/1ps
module ps_cfg_loader_test;
  localparam int RH = 4;
  localparam int HP = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  img_len = '0;
  logic        byp_flag = 1'b0;
  logic [31:0] byp_key = '0;
  logic        byp_clr;
  logic        bs_valid = 1'b0;
  logic [7:0]  bs_data = '0;
  logic        bs_ready;
  logic        cfg_n_o, cfg_n_oe, dclk_o, dclk_oe, dat_o, dat_oe;
  logic        status_n_i = 1'b1;
  logic        cdone_i = 1'b1;
  logic        busy, done, fail;
  logic [31:0] elapsed;

  ps_cfg_loader #(.RESET_HOLD(RH), .HALF_PER(HP), .SYNC_STAGES(2),
                  .LEN_W(8), .CNT_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .img_len(img_len),
    .byp_flag(byp_flag), .byp_key(byp_key), .byp_clr(byp_clr),
    .bs_valid(bs_valid), .bs_data(bs_data), .bs_ready(bs_ready),
    .cfg_n_o(cfg_n_o), .cfg_n_oe(cfg_n_oe), .dclk_o(dclk_o), .dclk_oe(dclk_oe),
    .dat_o(dat_o), .dat_oe(dat_oe), .status_n_i(status_n_i), .cdone_i(cdone_i),
    .busy(busy), .done(done), .fail(fail), .elapsed(elapsed));

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(input int i);
    return 8'(i * 53 + 29) ^ 8'h96;
  endfunction

  // controls written only by the test process
  logic clr_req = 1'b0;
  int   done_at = 0, ack_delay = 2, feed_len = 0;
  logic stall = 1'b0;

  // target model state, written only by the model process
  int   acc_idx = 0, base = 0, cyc = 0, busy_cyc = 0, got_done = 0, got_fail = 0;
  int   got_clr = 0, el_cap = -1, cfg_low = 0, max_low = 0, rx_bits = 0;
  int   seq_err = 0, oe_err = 0;
  logic prev_dclk = 1'b0, prev_dat = 1'b0, prev_busy = 1'b0;
  logic rx_mem [0:255];

  always @(posedge clk) if (bs_valid && bs_ready) acc_idx <= acc_idx + 1;

  always @(negedge clk) begin
    cyc++;
    if (clr_req) begin
      base = acc_idx; busy_cyc = 0; got_done = 0; got_fail = 0; got_clr = 0;
      el_cap = -1; max_low = 0; rx_bits = 0; seq_err = 0; oe_err = 0;
    end
    if (busy) busy_cyc++;
    if (done) got_done++;
    if (fail) got_fail++;
    if (byp_clr) got_clr++;
    if (done || fail) begin
      el_cap = int'(elapsed);
      if (cfg_n_oe || dclk_oe || dat_oe) oe_err++;
    end
    if (busy && !(cfg_n_oe && dclk_oe && dat_oe)) oe_err++;
    if (busy && !prev_busy && (!cfg_n_o || dclk_o)) seq_err++;
    if (cfg_n_oe && !cfg_n_o) cfg_low++; else cfg_low = 0;
    if (cfg_low > max_low) max_low = cfg_low;
    status_n_i = !(cfg_n_oe && !cfg_n_o && cfg_low >= ack_delay);
    if (!status_n_i) cdone_i = 1'b0;
    if (dclk_oe && dclk_o && !prev_dclk) begin
      if (!status_n_i || !cfg_n_o) seq_err++;
      if (rx_bits < 256) rx_mem[rx_bits] = dat_o;
      rx_bits++;
      if (done_at != 0 && rx_bits == done_at) cdone_i = 1'b1;
    end
    if (dclk_o && prev_dclk && dat_o != prev_dat) seq_err++;
    prev_dclk = dclk_o; prev_dat = dat_o; prev_busy = busy;
    bs_data  = gen(acc_idx - base);
    bs_valid = (acc_idx - base < feed_len) && !(stall && (cyc % 7) < 3);
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic prep(input int len, input int dbyte, input logic stl);
    img_len  = 8'(len);
    feed_len = len;
    done_at  = (dbyte == 0) ? 0 : 8 * (dbyte - 1) + 4;
    stall    = stl;
    clr_req  = 1'b1; step(); clr_req = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1; step(); start = 1'b0;
  endtask

  task automatic wait_end();
    int k = 0;
    while (!(got_done != 0 || got_fail != 0) && k < 20000) begin step(); k++; end
    repeat (3) step();
  endtask

  task automatic check_load(input string tag, input int pass, input int nbytes);
    int bad = 0;
    chk(tag, "done pulses", got_done, pass);
    chk(tag, "fail pulses", got_fail, 1 - pass);
    chk("R7", "bytes consumed", acc_idx - base, nbytes);
    chk("R5", "rising edges", rx_bits, 8 * nbytes);
    for (int b = 0; b < nbytes; b++) begin
      logic [7:0] g = gen(b);
      for (int k = 0; k < 8; k++) if (rx_mem[b*8+k] != g[k]) bad++;
    end
    chk("R5", "bit mismatches", bad, 0);
    chk("R11", "elapsed vs busy cycles", el_cap, busy_cyc);
    chk("R2", "config low long enough", int'(max_low >= RH), 1);
    chk("R4", "sequence/data errors", seq_err, 0);
    chk("R1", "enable errors", oe_err, 0);
  endtask

  // len, done byte (0 = never), expect pass, stall
  localparam int VEC [6][4] = '{
    '{4, 2, 1, 0}, '{3, 0, 0, 1}, '{3, 3, 0, 0},
    '{5, 1, 1, 1}, '{6, 5, 1, 0}, '{1, 0, 0, 0}};

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 / R11 reset state
    chk("R1", "reset enables", {cfg_n_oe, dclk_oe, dat_oe}, 0);
    chk("R1", "reset busy", busy, 0);
    chk("R7", "reset ready", bs_ready, 0);
    chk("R11", "reset pulses", {done, fail}, 0);
    chk("R11", "reset elapsed", elapsed, 0);

    for (int v = 0; v < 6; v++) begin
      int nb;
      nb = (VEC[v][2] == 1) ? VEC[v][1] : VEC[v][0];
      prep(VEC[v][0], VEC[v][1], VEC[v][3] != 0);
      pulse_start();
      wait_end();
      check_load((VEC[v][2] == 1) ? "R8" : "R9", VEC[v][2], nb);
    end

    // R10: wrong key runs a normal load
    byp_flag = 1'b1; byp_key = 32'hAFFE_AFFF;
    prep(2, 1, 1'b0);
    pulse_start();
    wait_end();
    check_load("R10", 1, 1);
    chk("R10", "clear pulses on wrong key", got_clr, 0);
    byp_flag = 1'b0;

    // R3: target holds its acknowledge back
    ack_delay = 60;
    prep(2, 1, 1'b0);
    pulse_start();
    repeat (40) step();
    chk("R3", "config still driven low", {cfg_n_oe, cfg_n_o}, 2'b10);
    chk("R3", "no bits while held", rx_bits, 0);
    wait_end();
    chk("R3", "low stretch covers hold", int'(max_low >= 60), 1);
    check_load("R8", 1, 1);
    ack_delay = 2;

    // R10: valid bypass
    byp_flag = 1'b1; byp_key = 32'hAFFE_AFFE;
    prep(3, 0, 1'b0);
    pulse_start();
    wait_end();
    chk("R10", "bypass done", got_done, 1);
    chk("R10", "bypass fail", got_fail, 0);
    chk("R10", "bypass clear", got_clr, 1);
    chk("R10", "bypass busy cycles", busy_cyc, 0);
    chk("R10", "bypass elapsed", el_cap, 0);
    chk("R10", "bypass edges", rx_bits, 0);
    byp_flag = 1'b0;
    prep(3, 2, 1'b0);
    pulse_start();
    wait_end();
    check_load("R10", 1, 2);

    // R12: start while busy
    prep(4, 3, 1'b0);
    pulse_start();
    repeat (30) step();
    pulse_start();
    wait_end();
    check_load("R12", 1, 3);

    // R9: zero-length image
    prep(0, 0, 1'b0);
    pulse_start();
    wait_end();
    check_load("R9", 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule